// File: doc/BRIEF.md
# Ternary CAM Storage Slot

This block is one slot of a content-addressable memory. It holds a stored word, an optional per-bit don't-care mask and a valid flag. On every clock edge it receives a two-bit command and a key word, which are broadcast to all slots, and it returns one registered hit bit. Priority encoding, address decoding and the choice of slot to overwrite all belong to the surrounding array.

A write command loads the key and the accompanying mask into the slot and marks the slot valid. A search command compares the stored word with the key, skipping every position whose mask bit is set, and registers the result. Any other command leaves the slot untouched and drives the hit output low on the next edge. The `TERNARY` parameter chooses between a masked slot and a plain binary slot in which the mask port is ignored.

Top module: `tcam_slot`

## Requirements
- R1: After reset the slot is invalid and `hit` is 0. A search of an invalid slot returns `hit`=0 for any key.
- R2: The command encoding is `cmd`=0 idle, `cmd`=1 search, `cmd`=2 write and `cmd`=3 idle. `hit` can be 1 only in the cycle after a search.
- R3: A write stores `key` as the word and `mask_in` as the mask, and it sets the valid flag at the same clock edge. `hit` is 0 in the cycle after a write.
- R4: In the cycle after a search of a valid slot, `hit` is 1 exactly when every bit position with a stored mask bit of 0 has equal stored and key values.
- R5: A stored mask bit of 1 makes that position don't-care. A valid slot written with an all-ones mask matches every key.
- R6: Idle commands (0 and 3) leave the stored word, mask and valid flag unchanged and drive `hit` to 0 in the next cycle. A later search shows that the stored contents are the same as before.
- R7: A search issued in the cycle right after a write compares against the newly written word and mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | Command: 0 idle, 1 search, 2 write, 3 idle |
| key | input | DATA_W | Broadcast key; written as the word on a write |
| mask_in | input | DATA_W | Mask written with the word; 1 = don't-care |
| hit | output | 1 | Registered match result of the previous search |

## Verification
Two functions can meet across a single edge. The first is a write that replaces the contents while the hit register still shows the previous search. The second is a search that must already use those new contents one cycle later. The bench produces both by issuing writes between searches, including back-to-back write-then-search pairs, and by following a successful search directly with a write. A bench model then checks that `hit` falls on the write and that the next search result agrees with the new word and mask, not the old ones.

// File: rtl/tcam_slot_pkg.sv
package tcam_slot_pkg;

   typedef enum logic [1:0] {
      SLOT_IDLE   = 2'd0,
      SLOT_SEARCH = 2'd1,
      SLOT_WRITE  = 2'd2,
      SLOT_NOP    = 2'd3
   } slot_cmd_e;

   function automatic logic is_search(input logic [1:0] c);
      return c == SLOT_SEARCH;
   endfunction

   function automatic logic is_write(input logic [1:0] c);
      return c == SLOT_WRITE;
   endfunction

endpackage

// File: rtl/tcam_slot_store.sv
module tcam_slot_store #(
   parameter int DATA_W  = 16,
   parameter bit TERNARY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_word,
   input  logic [DATA_W-1:0] wr_mask,
   output logic [DATA_W-1:0] word_q,
   output logic [DATA_W-1:0] mask_q,
   output logic              valid_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= '0;
         valid_q <= 1'b0;
      end else if (wr_en) begin
         word_q  <= wr_word;
         valid_q <= 1'b1;
      end
   end

   generate
      if (TERNARY) begin : g_mask_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     mask_q <= '0;
            else if (wr_en) mask_q <= wr_mask;
         end
      end else begin : g_no_mask
         logic unused_mask;
         assign unused_mask = ^wr_mask;
         assign mask_q      = '0;
      end
   endgenerate

endmodule

// File: rtl/tcam_slot_compare.sv
module tcam_slot_compare #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] word,
   input  logic [DATA_W-1:0] mask,
   input  logic              valid,
   input  logic [DATA_W-1:0] key,
   output logic              equal
);

   logic [DATA_W-1:0] bit_miss;

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         assign bit_miss[b] = (word[b] ^ key[b]) & ~mask[b];
      end
   endgenerate

   assign equal = valid & ~|bit_miss;

endmodule

// File: rtl/tcam_slot.sv
module tcam_slot
   import tcam_slot_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter bit TERNARY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd,
   input  logic [DATA_W-1:0] key,
   input  logic [DATA_W-1:0] mask_in,
   output logic              hit
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("tcam_slot: DATA_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] stored_word;
   logic [DATA_W-1:0] stored_mask;
   logic              stored_valid;
   logic              cmp_equal;
   logic              do_write;
   logic              do_search;

   assign do_write  = is_write(cmd);
   assign do_search = is_search(cmd);

   tcam_slot_store #(.DATA_W(DATA_W), .TERNARY(TERNARY)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (do_write),
      .wr_word (key),
      .wr_mask (mask_in),
      .word_q  (stored_word),
      .mask_q  (stored_mask),
      .valid_q (stored_valid)
   );

   tcam_slot_compare #(.DATA_W(DATA_W)) u_cmp (
      .word  (stored_word),
      .mask  (stored_mask),
      .valid (stored_valid),
      .key   (key),
      .equal (cmp_equal)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit <= 1'b0;
      else        hit <= do_search & cmp_equal;
   end

endmodule

// File: rtl/tcam_slot_chk.sv
module tcam_slot_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cmd,
   input logic [DATA_W-1:0] key,
   input logic [DATA_W-1:0] mask_in,
   input logic              hit,
   input logic [DATA_W-1:0] word_q,
   input logic [DATA_W-1:0] mask_q,
   input logic              valid_q
);

   logic unused_chk;
   assign unused_chk = ^mask_in;

   assert_hit_after_search_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> $past(cmd) == 2'd1);

   assert_write_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == 2'd2 |=> (word_q == $past(key)) && valid_q && !hit);

   assert_invalid_no_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 2'd1 && !valid_q) |=> !hit);

   assert_search_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 2'd1 && valid_q && (((word_q ^ key) & ~mask_q) == '0)) |=> hit);

   assert_search_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 2'd1 && (((word_q ^ key) & ~mask_q) != '0)) |=> !hit);

   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 2'd0 || cmd == 2'd3) |=> $stable(word_q) && $stable(mask_q) && $stable(valid_q) && !hit);

endmodule

bind tcam_slot tcam_slot_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cmd     (cmd),
   .key     (key),
   .mask_in (mask_in),
   .hit     (hit),
   .word_q  (stored_word),
   .mask_q  (stored_mask),
   .valid_q (stored_valid)
);

// File: tb/tb_tcam_slot.sv
`timescale 1ns/1ps
module tb_tcam_slot;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   cmd = 2'd0;
   logic [W-1:0] key = '0;
   logic [W-1:0] mask_in = '0;
   logic         hit;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [W-1:0] m_word = '0;
   logic [W-1:0] m_mask = '0;
   bit           m_valid = 1'b0;

   always #5 clk = ~clk;

   tcam_slot #(.DATA_W(W), .TERNARY(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .key(key), .mask_in(mask_in), .hit(hit)
   );

   function automatic bit exp_hit(input logic [1:0] c, input logic [W-1:0] k);
      if (c != 2'd1 || !m_valid) return 1'b0;
      return ((m_word ^ k) & ~m_mask) == '0;
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: hit=%0b expected %0b", req, act, exp);
      end
   endtask

   // drive at negedge, let one edge pass, compare hit just after it
   task automatic step(input string req, input logic [1:0] c,
                       input logic [W-1:0] k, input logic [W-1:0] m);
      bit e;
      @(negedge clk);
      cmd = c; key = k; mask_in = m;
      e = exp_hit(c, k);
      @(posedge clk);
      #2;
      if (c == 2'd2) begin
         m_word = k; m_mask = m; m_valid = 1'b1;
      end
      check(req, hit, e);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run hung, done=0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [W-1:0] rk;
      logic [W-1:0] rm;
      logic [1:0]   rc;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #2;
      check("R1 reset", hit, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // invalid slot never matches (reset mask is zero, key matches reset word)
      step("R1 invalid search", 2'd1, 16'h0000, 16'h0000);
      step("R1 invalid search", 2'd1, 16'hFFFF, 16'hFFFF);

      // write then search immediately
      step("R3 write hit low", 2'd2, 16'hA5C3, 16'h0000);
      step("R7 search after write", 2'd1, 16'hA5C3, 16'h0000);
      step("R4 exact miss", 2'd1, 16'hA5C2, 16'h0000);
      step("R2 cmd3 idle", 2'd3, 16'hA5C3, 16'h0000);
      step("R6 hold after idle", 2'd1, 16'hA5C3, 16'h0000);
      step("R2 cmd0 idle", 2'd0, 16'hA5C3, 16'h0000);
      step("R6 hold after cmd0", 2'd1, 16'hA5C3, 16'hFFFF);

      // ternary masks
      step("R3 write masked", 2'd2, 16'h1200, 16'h00FF);
      step("R5 low byte dont-care", 2'd1, 16'h12AB, 16'h0000);
      step("R5 high byte cares", 2'd1, 16'h13AB, 16'h0000);
      step("R2 hit then write", 2'd1, 16'h1255, 16'h0000);
      step("R3 write drops hit", 2'd2, 16'h0000, 16'hFFFF);
      step("R5 full mask any key", 2'd1, 16'hBEEF, 16'h0000);
      step("R5 full mask any key", 2'd1, 16'h0001, 16'h0000);
      step("R7 rewrite exact", 2'd2, 16'h7777, 16'h0000);
      step("R7 old mask gone", 2'd1, 16'hBEEF, 16'h0000);
      step("R7 new word", 2'd1, 16'h7777, 16'h0000);

      // constrained random
      for (int i = 0; i < 600; i++) begin
         rc = 2'($urandom_range(0, 3));
         rm = 16'($urandom) & 16'($urandom);
         if ($urandom_range(0, 1) == 1)
            rk = m_word ^ (16'($urandom) & m_mask);
         else
            rk = 16'($urandom);
         if (rc == 2'd1)      step("R4 random search", rc, rk, rm);
         else if (rc == 2'd2) step("R3 random write", rc, rk, rm);
         else                 step("R6 random idle", rc, rk, rm);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule